// File: doc/BRIEF.md
# Processor stack and interrupt sequencer

This block owns the stack pointer, program counter and status register of a small 8-bit processor with a 16-bit program counter. It carries out the control-flow commands that touch the stack: jump, subroutine call and return, return from interrupt, and single-byte push and pull. Each command runs one memory access per cycle over a byte-wide memory port. The stack lives in page one of memory, so every stack address is `0x01` followed by the 8-bit stack pointer.

The block also takes a maskable request, which is level-sensitive, and a non-maskable request, which is edge-detected and held until it is serviced. Between commands, a pending request starts an entry sequence. The sequence saves the resume address and the status byte, sets the interrupt-disable flag and loads the program counter from a vector.

A caller offers a command with `cmd_valid` and sees it taken in a cycle where `cmd_ready` is high. `busy` stays high while the block steps through the memory accesses, and `done` pulses for one cycle when the sequence completes. Instruction decode and the ALU sit outside this block.

Top module: `stack_irq_seq`

## Requirements
- R1: Every stack access uses address `{0x01, pointer}` (page one). After reset the stack pointer is 0xFF, the program counter is 0x0000 and the status is 0x04.
- R2: A push (`cmd_op`=4) writes `cmd_data` at the current pointer and then decrements the pointer. A pull (`cmd_op`=5) first increments the pointer, then reads that address into `pull_data`. A pull writes nothing, so a pulled byte stays in memory.
- R3: Interrupt entry writes three bytes in this order: program counter high byte, program counter low byte, status. The pointer drops by three. The program counter is then loaded from the vector, reading the low byte before the high byte: 0xFFFA/0xFFFB for a non-maskable request and 0xFFFE/0xFFFF for a maskable one.
- R4: The interrupt-disable flag is status bit 2. Entry sets it only after the status byte is written, so the stacked copy holds the earlier flag value.
- R5: A call (`cmd_op`=1, target on `cmd_addr`) pushes (program counter − 1), high byte first, then jumps to the target. A return (`cmd_op`=2) pulls the low byte, then the high byte, and loads the pulled value + 1.
- R6: A return from interrupt (`cmd_op`=3) pulls the status first, then the low and high address bytes. This restores the status and the program counter that entry had saved.
- R7: A maskable request is ignored while status bit 2 is set. A non-maskable request is taken whatever that bit holds.
- R8: A rising edge on `nmi_in` is latched until serviced, including an edge that arrives while a command is running. A held-high level does not trigger a second entry. When both requests are pending, the non-maskable one is served first.
- R9: The stack pointer wraps modulo 256 and never leaves page one. A pull at 0xFF reads 0x100, and a push at 0x00 leaves the pointer at 0xFF.
- R10: `cmd_ready` is high only when the block is idle and no interrupt is starting. `busy` is high while a multi-cycle sequence runs, and `done` pulses for one cycle, with `busy` low, when any command or entry completes.
- R11: A jump (`cmd_op`=0) loads the program counter from `cmd_addr` and the status from `cmd_data` in one cycle, with no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_op | input | 3 | Command code (0 jump, 1 call, 2 return, 3 return from interrupt, 4 push, 5 pull) |
| cmd_addr | input | 16 | Jump or call target |
| cmd_data | input | 8 | Push byte, or new status for a jump |
| cmd_ready | output | 1 | Command taken this cycle when valid |
| irq_in | input | 1 | Maskable request, level-sensitive |
| nmi_in | input | 1 | Non-maskable request, rising-edge |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |
| pc | output | 16 | Program counter |
| status | output | 8 | Status register (bit 2 = interrupt disable) |
| sp | output | 8 | Stack pointer |
| pull_data | output | 8 | Last byte pulled |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong pointer value shows up at once at the `sp` port. A push or pull at the wrong address puts a byte in the wrong slot, and that byte comes back wrong on the next matching pull or return, often many commands later. The bench therefore mirrors page one and compares every pulled byte and every restored program counter. A wrong flag-update order or vector choice changes the stacked status byte or the program counter at the end of the five-cycle entry. A lost or repeated non-maskable request shows up as a missing entry or an extra one, visible on `busy` and on the pointer.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 16;
    localparam int IFLAG_BIT = 2;
    localparam logic [DATA_W-1:0] STACK_PAGE = 8'h01;

    typedef enum logic [2:0] {
        OP_JUMP = 3'd0,
        OP_CALL = 3'd1,
        OP_RET  = 3'd2,
        OP_RTI  = 3'd3,
        OP_PUSH = 3'd4,
        OP_PULL = 3'd5
    } cmd_op_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_INT_PCH, ST_INT_PCL, ST_INT_PSR, ST_VEC_LO, ST_VEC_HI,
        ST_CALL_HI, ST_CALL_LO, ST_RET_LO, ST_RET_HI,
        ST_RTI_PSR, ST_RTI_LO, ST_RTI_HI, ST_PUSH, ST_PULL
    } step_e;

    typedef enum logic [1:0] {SP_HOLD, SP_DEC, SP_INC} sp_op_e;

    typedef struct packed {
        logic   we;
        logic   re;
        sp_op_e sp_op;
        logic   vec;
    } step_ctl_t;

    function automatic step_ctl_t step_decode(step_e s);
        step_ctl_t c;
        c = '{we: 1'b0, re: 1'b0, sp_op: SP_HOLD, vec: 1'b0};
        case (s)
            ST_INT_PCH, ST_INT_PCL, ST_INT_PSR,
            ST_CALL_HI, ST_CALL_LO, ST_PUSH: begin
                c.we = 1'b1; c.sp_op = SP_DEC;
            end
            ST_RET_LO, ST_RET_HI, ST_RTI_PSR,
            ST_RTI_LO, ST_RTI_HI, ST_PULL: begin
                c.re = 1'b1; c.sp_op = SP_INC;
            end
            ST_VEC_LO, ST_VEC_HI: begin
                c.re = 1'b1; c.vec = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

    function automatic logic is_last(step_e s);
        return (s == ST_VEC_HI) || (s == ST_CALL_LO) || (s == ST_RET_HI) ||
               (s == ST_RTI_HI) || (s == ST_PUSH) || (s == ST_PULL);
    endfunction
endpackage

// File: rtl/stk_pointer.sv
module stk_pointer
    import stk_pkg::*;
#(
    parameter logic [DATA_W-1:0] RESET_SP = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  sp_op_e            op,
    output logic [DATA_W-1:0] sp,
    output logic [ADDR_W-1:0] stack_addr
);
    logic [DATA_W-1:0] sp_inc;

    assign sp_inc     = sp + 1'b1;
    assign stack_addr = (op == SP_INC) ? {STACK_PAGE, sp_inc} : {STACK_PAGE, sp};

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= RESET_SP;
        end else begin
            case (op)
                SP_DEC:  sp <= sp - 1'b1;
                SP_INC:  sp <= sp_inc;
                default: sp <= sp;
            endcase
        end
    end
endmodule

// File: rtl/stk_irq_arb.sv
module stk_irq_arb (
    input  logic clk,
    input  logic rst,
    input  logic nmi_in,
    input  logic irq_in,
    input  logic i_flag,
    input  logic idle,
    output logic nmi_pend,
    output logic take_int,
    output logic take_nmi
);
    logic nmi_q;

    assign take_nmi = idle && nmi_pend;
    assign take_int = idle && (nmi_pend || (irq_in && !i_flag));

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_q <= nmi_in;
            if (nmi_in && !nmi_q) begin
                nmi_pend <= 1'b1;
            end else if (take_nmi) begin
                nmi_pend <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/stk_seq_ctrl.sv
module stk_seq_ctrl
    import stk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take_int,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    output step_e      state,
    output logic       idle,
    output logic       cmd_ready,
    output logic       cmd_go
);
    step_e nxt;

    assign idle      = (state == ST_IDLE);
    assign cmd_ready = idle && !take_int;
    assign cmd_go    = cmd_valid && cmd_ready;

    always_comb begin
        nxt = ST_IDLE;
        case (state)
            ST_IDLE: begin
                if (take_int) begin
                    nxt = ST_INT_PCH;
                end else if (cmd_go) begin
                    case (cmd_op)
                        OP_CALL: nxt = ST_CALL_HI;
                        OP_RET:  nxt = ST_RET_LO;
                        OP_RTI:  nxt = ST_RTI_PSR;
                        OP_PUSH: nxt = ST_PUSH;
                        OP_PULL: nxt = ST_PULL;
                        default: nxt = ST_IDLE;
                    endcase
                end
            end
            ST_INT_PCH: nxt = ST_INT_PCL;
            ST_INT_PCL: nxt = ST_INT_PSR;
            ST_INT_PSR: nxt = ST_VEC_LO;
            ST_VEC_LO:  nxt = ST_VEC_HI;
            ST_CALL_HI: nxt = ST_CALL_LO;
            ST_RET_LO:  nxt = ST_RET_HI;
            ST_RTI_PSR: nxt = ST_RTI_LO;
            ST_RTI_LO:  nxt = ST_RTI_HI;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/stack_irq_seq.sv
module stack_irq_seq
    import stk_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC     = 16'h0000,
    parameter logic [DATA_W-1:0] RESET_STATUS = 8'h04,
    parameter logic [ADDR_W-1:0] NMI_VEC      = 16'hFFFA,
    parameter logic [ADDR_W-1:0] IRQ_VEC      = 16'hFFFE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              cmd_ready,
    input  logic              irq_in,
    input  logic              nmi_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] sp,
    output logic [DATA_W-1:0] pull_data,
    output logic              busy,
    output logic              done
);
    step_e             state;
    step_ctl_t         ctl;
    logic              idle, cmd_go, take_int, take_nmi, nmi_pend;
    logic              is_nmi;
    logic [ADDR_W-1:0] stack_addr, hold, pc_m1, vec_base;

    stk_seq_ctrl u_ctrl (
        .clk(clk), .rst(rst), .take_int(take_int), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .state(state), .idle(idle), .cmd_ready(cmd_ready),
        .cmd_go(cmd_go)
    );

    stk_irq_arb u_arb (
        .clk(clk), .rst(rst), .nmi_in(nmi_in), .irq_in(irq_in),
        .i_flag(status[IFLAG_BIT]), .idle(idle), .nmi_pend(nmi_pend),
        .take_int(take_int), .take_nmi(take_nmi)
    );

    assign ctl = step_decode(state);

    stk_pointer u_sp (
        .clk(clk), .rst(rst), .op(ctl.sp_op), .sp(sp), .stack_addr(stack_addr)
    );

    assign pc_m1    = pc - 1'b1;
    assign vec_base = is_nmi ? NMI_VEC : IRQ_VEC;
    assign busy     = !idle;
    assign mem_we   = ctl.we;
    assign mem_re   = ctl.re;
    assign mem_addr = ctl.vec ? {vec_base[ADDR_W-1:1], (state == ST_VEC_HI)} : stack_addr;

    always_comb begin
        case (state)
            ST_INT_PCH: mem_wdata = pc[ADDR_W-1:DATA_W];
            ST_INT_PCL: mem_wdata = pc[DATA_W-1:0];
            ST_INT_PSR: mem_wdata = status;
            ST_CALL_HI: mem_wdata = pc_m1[ADDR_W-1:DATA_W];
            ST_CALL_LO: mem_wdata = pc_m1[DATA_W-1:0];
            ST_PUSH:    mem_wdata = hold[DATA_W-1:0];
            default:    mem_wdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc        <= RESET_PC;
            status    <= RESET_STATUS;
            hold      <= '0;
            is_nmi    <= 1'b0;
            pull_data <= '0;
            done      <= 1'b0;
        end else begin
            done <= is_last(state) || (cmd_go && (cmd_op == OP_JUMP));
            if (idle && take_int) begin
                is_nmi <= take_nmi;
            end else if (cmd_go) begin
                case (cmd_op)
                    OP_JUMP: begin
                        pc     <= cmd_addr;
                        status <= cmd_data;
                    end
                    OP_CALL: hold <= cmd_addr;
                    OP_PUSH: hold <= {{(ADDR_W-DATA_W){1'b0}}, cmd_data};
                    default: ;
                endcase
            end
            case (state)
                ST_INT_PSR: status[IFLAG_BIT] <= 1'b1;
                ST_VEC_LO, ST_RET_LO, ST_RTI_LO: hold[DATA_W-1:0] <= mem_rdata;
                ST_VEC_HI, ST_RTI_HI: pc <= {mem_rdata, hold[DATA_W-1:0]};
                ST_RET_HI:  pc <= {mem_rdata, hold[DATA_W-1:0]} + 1'b1;
                ST_RTI_PSR: status <= mem_rdata;
                ST_CALL_LO: pc <= hold;
                ST_PULL:    pull_data <= mem_rdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/stk_seq_chk.sv
module stk_seq_chk
    import stk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] sp,
    input logic [DATA_W-1:0] status,
    input logic              irq_in,
    input logic              cmd_valid,
    input logic              nmi_pend,
    input step_e             state
);
    AST_WRITE_PAGE_ONE: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[ADDR_W-1:DATA_W] == STACK_PAGE)); // R1

    AST_PUSH_DEC: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (sp == $past(sp) - 8'd1)); // R2

    AST_PULL_INC: assert property (@(posedge clk) disable iff (rst)
        (mem_re && mem_addr[ADDR_W-1:DATA_W] == STACK_PAGE) |=> (sp == $past(sp) + 8'd1)); // R2

    AST_VEC_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        (mem_addr[ADDR_W-1:DATA_W] == 8'hFF && (mem_we || mem_re)) |-> (mem_re && !mem_we)); // R3

    AST_IFLAG_AFTER_PSR: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INT_PSR) |=> status[IFLAG_BIT]); // R4

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (!busy && status[IFLAG_BIT] && !nmi_pend && irq_in && !cmd_valid) |=> !busy); // R7

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (done && !cmd_valid && !irq_in && !nmi_pend) |=> !done); // R10
endmodule

bind stack_irq_seq stk_seq_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .mem_we(mem_we),
    .mem_re(mem_re), .mem_addr(mem_addr), .sp(sp), .status(status),
    .irq_in(irq_in), .cmd_valid(cmd_valid), .nmi_pend(nmi_pend), .state(state)
);

// File: tb/stack_irq_seq_tb.sv
module stack_irq_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [15:0] cmd_addr = 16'h0;
    logic [7:0]  cmd_data = 8'h0;
    logic        cmd_ready, irq_in = 1'b0, nmi_in = 1'b0;
    logic [15:0] mem_addr, pc;
    logic        mem_we, mem_re, busy, done;
    logic [7:0]  mem_wdata, mem_rdata, status, sp, pull_data;

    logic [7:0]  st [256];
    logic [7:0]  mst [256];
    logic [7:0]  msp, mp;
    logic [15:0] mpc;
    logic [15:0] wl_addr [16];
    logic [7:0]  wl_data [16];
    int          wn = 0;
    int          n_chk = 0, n_fail = 0, cyc = 0;

    always #10 clk = ~clk;

    stack_irq_seq u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
        .irq_in(irq_in), .nmi_in(nmi_in), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_re(mem_re), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc(pc),
        .status(status), .sp(sp), .pull_data(pull_data), .busy(busy), .done(done)
    );

    always_comb begin
        case (mem_addr)
            16'hFFFA: mem_rdata = 8'h78;
            16'hFFFB: mem_rdata = 8'h56;
            16'hFFFE: mem_rdata = 8'h34;
            16'hFFFF: mem_rdata = 8'h12;
            default:  mem_rdata = (mem_addr[15:8] == 8'h01) ? st[mem_addr[7:0]] : 8'h00;
        endcase
    end

    always @(posedge clk) begin
        if (mem_we) begin
            if (mem_addr[15:8] == 8'h01) st[mem_addr[7:0]] <= mem_wdata;
            if (wn < 16) begin
                wl_addr[wn] = mem_addr;
                wl_data[wn] = mem_wdata;
            end
            wn = wn + 1;
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 100000) begin
            n_chk = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual cycles %0d expected below 100000", cyc);
            finish_run();
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk("R10 completion", {31'd0, done}, 32'd1);
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        wait_done();
    endtask

    task automatic model_cmd(input logic [2:0] op, input logic [15:0] a, input logic [7:0] d);
        logic [15:0] r;
        logic [7:0]  lo;
        case (op)
            3'd0: begin mpc = a; mp = d; end
            3'd1: begin
                r = mpc - 16'd1;
                mst[msp] = r[15:8]; msp = msp - 8'd1;
                mst[msp] = r[7:0];  msp = msp - 8'd1;
                mpc = a;
            end
            3'd2: begin
                msp = msp + 8'd1; lo = mst[msp];
                msp = msp + 8'd1; mpc = {mst[msp], lo} + 16'd1;
            end
            3'd3: begin
                msp = msp + 8'd1; mp = mst[msp];
                msp = msp + 8'd1; lo = mst[msp];
                msp = msp + 8'd1; mpc = {mst[msp], lo};
            end
            3'd4: begin mst[msp] = d; msp = msp - 8'd1; end
            default: msp = msp + 8'd1;
        endcase
    endtask

    task automatic run_both(input logic [2:0] op, input logic [15:0] a, input logic [7:0] d,
                            input string req);
        model_cmd(op, a, d);
        do_cmd(op, a, d);
        chk({req, " pc"}, {16'd0, pc}, {16'd0, mpc});
        chk({req, " sp"}, {24'd0, sp}, {24'd0, msp});
        chk({req, " status"}, {24'd0, status}, {24'd0, mp});
        if (op == 3'd5) chk({req, " pull data"}, {24'd0, pull_data}, {24'd0, mst[msp]});
    endtask

    task automatic wait_int();
        int n = 0;
        @(negedge clk);
        while (!done && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk("R3 entry completes", {31'd0, done}, 32'd1);
    endtask

    initial begin
        logic [2:0] op;
        int busy_seen;
        for (int i = 0; i < 256; i++) begin
            st[i] = 8'h00;
            mst[i] = 8'h00;
        end
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset sp", {24'd0, sp}, 32'hFF);
        chk("R1 reset pc", {16'd0, pc}, 32'h0);
        chk("R1 reset status", {24'd0, status}, 32'h04);
        chk("R10 reset busy/done", {30'd0, busy, done}, 32'd0);
        msp = 8'hFF; mpc = 16'h0; mp = 8'h04;

        // random phase: R2 R5 R6 R9 R11 against the bench model
        for (int k = 0; k < 300; k++) begin
            op = 3'($urandom_range(0, 5));
            case (op)
                3'd0: run_both(op, 16'($urandom), 8'($urandom), "R11 jump");
                3'd1: run_both(op, 16'($urandom), 8'h00, "R5 call");
                3'd2: run_both(op, 16'h0, 8'h00, "R5 return");
                3'd3: run_both(op, 16'h0, 8'h00, "R6 rti");
                3'd4: run_both(op, 16'h0, 8'($urandom), "R2 push");
                default: run_both(op, 16'h0, 8'h00, "R2 R9 pull");
            endcase
        end

        // wrap-around from a fresh reset
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        msp = 8'hFF; mpc = 16'h0; mp = 8'h04;
        wn = 0;
        run_both(3'd5, 16'h0, 8'h00, "R9 pull wrap");
        chk("R9 pointer wrapped", {24'd0, sp}, 32'h00);
        chk("R2 pull writes nothing", wn, 0);
        run_both(3'd4, 16'h0, 8'hA5, "R9 push wrap");
        chk("R9 push at 0x100", {16'd0, wl_addr[0]}, 32'h0100);

        // call/return directed
        run_both(3'd0, 16'h1000, 8'h04, "R11 jump");
        wn = 0;
        run_both(3'd1, 16'h2000, 8'h00, "R5 call");
        chk("R5 call high byte", {16'd0, wl_addr[0], wl_data[0]}, {16'd0, 8'h01, sp + 8'd2, 8'h0F});
        chk("R5 call low byte", {16'd0, wl_addr[1], wl_data[1]}, {16'd0, 8'h01, sp + 8'd1, 8'hFF});
        run_both(3'd2, 16'h0, 8'h00, "R5 return");
        chk("R5 return address", {16'd0, pc}, 32'h1000);

        // handshake
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd4; cmd_data = 8'h11;
        chk("R10 ready when idle", {31'd0, cmd_ready}, 32'd1);
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        chk("R10 busy during push", {30'd0, busy, cmd_ready}, 32'd2);
        wait_done();
        model_cmd(3'd4, 16'h0, 8'h11);

        // bring the pointer to 0xEB
        while (msp != 8'hEB) run_both(3'd4, 16'h0, 8'h5A, "R2 fill");

        // maskable entry
        run_both(3'd0, 16'h2F92, 8'h81, "R11 jump");
        wn = 0;
        @(negedge clk); irq_in = 1'b1;
        wait_int();
        irq_in = 1'b0;
        chk("R3 three writes", wn, 3);
        chk("R1 R3 first write", {8'd0, wl_addr[0], wl_data[0]}, {8'd0, 16'h01EB, 8'h2F});
        chk("R3 second write", {8'd0, wl_addr[1], wl_data[1]}, {8'd0, 16'h01EA, 8'h92});
        chk("R4 stacked status", {8'd0, wl_addr[2], wl_data[2]}, {8'd0, 16'h01E9, 8'h81});
        chk("R3 sp after entry", {24'd0, sp}, 32'hE8);
        chk("R3 irq vector", {16'd0, pc}, 32'h1234);
        chk("R4 flag set", {24'd0, status}, 32'h85);
        do_cmd(3'd3, 16'h0, 8'h00);
        chk("R6 rti pc", {16'd0, pc}, 32'h2F92);
        chk("R6 rti status", {24'd0, status}, 32'h81);
        chk("R6 rti sp", {24'd0, sp}, 32'hEB);

        // maskable request ignored while masked
        run_both(3'd0, 16'h4000, 8'h04, "R11 jump");
        @(negedge clk); irq_in = 1'b1;
        busy_seen = 0;
        repeat (8) begin
            @(negedge clk);
            if (busy) busy_seen++;
        end
        irq_in = 1'b0;
        chk("R7 masked irq no entry", busy_seen, 0);
        chk("R7 masked irq pc", {16'd0, pc}, 32'h4000);
        chk("R7 masked irq sp", {24'd0, sp}, 32'hEB);

        // non-maskable with flag set, level held
        wn = 0;
        @(negedge clk); nmi_in = 1'b1;
        wait_int();
        chk("R7 nmi taken while masked", {16'd0, pc}, 32'h5678);
        chk("R4 stacked status nmi", {24'd0, wl_data[2]}, 32'h04);
        busy_seen = 0;
        repeat (8) begin
            @(negedge clk);
            if (busy) busy_seen++;
        end
        chk("R8 held level no retrigger", busy_seen, 0);
        nmi_in = 1'b0;
        do_cmd(3'd3, 16'h0, 8'h00);
        chk("R6 rti after nmi pc", {16'd0, pc}, 32'h4000);
        chk("R6 rti after nmi sp", {24'd0, sp}, 32'hEB);

        // both pending: pulse arrives during a push
        run_both(3'd0, 16'h3000, 8'h00, "R11 jump");
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd4; cmd_data = 8'h77;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
        @(negedge clk); nmi_in = 1'b1; irq_in = 1'b1;
        @(negedge clk); nmi_in = 1'b0;
        chk("R10 push done", {31'd0, done}, 32'd1);
        wait_int();
        chk("R8 nmi wins pc", {16'd0, pc}, 32'h5678);
        chk("R8 latched pulse sp", {24'd0, sp}, 32'hE7);
        chk("R4 flag after entry", {31'd0, status[2]}, 32'd1);
        irq_in = 1'b0;
        @(negedge clk);
        chk("R7 irq held off", {31'd0, busy}, 32'd0);

        finish_run();
    end
endmodule